// File: doc/BRIEF.md
# Congradient Shading Unit

This block turns a raster-ordered stream of projected pixels, each carrying a color and a depth, into congradient words for a frame buffer. For every pixel it looks at the depths around it and reduces the local slope to a small gradient code. It then places the color above that code to form one stored word. The block holds one pixel back until its right-hand neighbour has arrived. This means a pixel's gradient is worked out while the next pixel is still coming in, and the stream keeps a rate of one pixel per clock.

A second, independent part is a programmable shading table. At display time the stored word is used as the table address. The table returns the shaded color for the present light position. Moving the light only requires rewriting the table; the frame buffer stays as it is.

Two gradient modes are selected by a pin. In horizontal-only mode the code comes from the left and right neighbours alone. In two-axis mode the code also uses the pixel directly above, which a line buffer supplies.

Top module: `cgs_shader`

## Requirements
- R1: The output word is `{color, code}`: the color fills the upper COLOR_W bits and the gradient code fills the low 5 bits.
- R2: With `bidir` low, code = gx, where gx = clamp(right_depth − left_depth, −2, +2) + 2, a value from 0 to 4.
- R3: With `bidir` high, code = 5·gy + gx, where gy = clamp(center_depth − upper_depth, −2, +2) + 2, a value from 0 to 24.
- R4: A neighbour that lies outside the image is replaced by the center pixel's depth. This covers the left neighbour in the first column, the right neighbour in the last column, and the upper neighbour in the first row of a frame.
- R5: When `out_ready` is held high, `in_ready` never drops, so one pixel is taken every cycle. Every accepted pixel yields exactly one output word, and the words come out in raster order.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_sof` keep their values, and no word is lost.
- R7: `in_sof` marks the first pixel of a frame. It comes out as `out_sof` on that pixel's word, and it restarts the column count and the first-row state.
- R8: A table read issued with `lut_rd_en` returns the stored entry on `lut_rd_data` in the next cycle, with `lut_rd_valid` high in that cycle only.
- R9: A read and a write to the same table address in the same cycle return the entry as it was before the write. The new value is seen from the next read on.
- R10: After reset, `out_valid` and `lut_rd_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bidir | input | 1 | 1 = two-axis gradient, 0 = horizontal only |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted when both this and in_valid are high |
| in_sof | input | 1 | First pixel of a frame |
| in_color | input | COLOR_W | Pixel color |
| in_depth | input | DEPTH_W | Pixel depth |
| out_valid | output | 1 | Congradient word present |
| out_ready | input | 1 | Downstream takes the word |
| out_sof | output | 1 | Word belongs to the first pixel of a frame |
| out_word | output | COLOR_W+5 | Color and gradient code |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_addr | input | COLOR_W+5 | Table write address |
| lut_wr_data | input | SHADE_W | Shaded color to store |
| lut_rd_en | input | 1 | Table read strobe |
| lut_rd_addr | input | COLOR_W+5 | Stored word used as the address |
| lut_rd_valid | output | 1 | Read data present |
| lut_rd_data | output | SHADE_W | Shaded color |

## Verification
Two events can fall in the same cycle. The first pair is in the stream: when the last pixel of a row is accepted, its left neighbour's word goes out, and the last pixel itself waits in a tail slot. In the next cycle the tail word goes out while the first pixel of the following row is accepted. The bench sends frames back to back, with the output both free-running and under a periodic backpressure pattern. It judges the result by comparing every word against codes it computes from the frame table, and by checking that the input never stalls while the output is free. The second pair is in the table: a write and a read to the same address are issued in one cycle. The bench expects the old entry back, then the new entry on the following read.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
   localparam int GRAD_W    = 5;
   localparam int AXIS_SPAN = 5;

   typedef enum logic {MODE_HORIZ = 1'b0, MODE_BOTH = 1'b1} grad_mode_e;

   // Clamp a depth difference to -2..+2 and bias it to 0..4.
   function automatic logic [2:0] axis_code(input int diff);
      if (diff > 1)       return 3'd4;
      else if (diff < -1) return 3'd0;
      else                return 3'(diff + 2);
   endfunction
endpackage

// File: rtl/cgs_line_buf.sv
module cgs_line_buf #(
   parameter int LINE_W  = 8,
   parameter int DEPTH_W = 6,
   localparam int COL_W  = $clog2(LINE_W)
) (
   input  logic               clk,
   input  logic [COL_W-1:0]   rd_col,
   output logic [DEPTH_W-1:0] rd_depth,
   input  logic               wr_en,
   input  logic [COL_W-1:0]   wr_col,
   input  logic [DEPTH_W-1:0] wr_depth
);
   logic [DEPTH_W-1:0] row_q [LINE_W];

   always_ff @(posedge clk) begin
      if (wr_en) row_q[wr_col] <= wr_depth;
   end

   assign rd_depth = row_q[rd_col];
endmodule

// File: rtl/cgs_grad_quant.sv
module cgs_grad_quant
   import cgs_pkg::*;
#(
   parameter int DEPTH_W = 6,
   parameter bit VERT_EN = 1'b1
) (
   input  logic [DEPTH_W-1:0] center,
   input  logic [DEPTH_W-1:0] left,
   input  logic [DEPTH_W-1:0] right,
   input  logic [DEPTH_W-1:0] upper,
   input  grad_mode_e         mode,
   output logic [GRAD_W-1:0]  code
);
   logic [2:0] gx;
   assign gx = axis_code(int'(right) - int'(left));

   generate
      if (VERT_EN) begin : g_two_axis
         logic [2:0] gy;
         assign gy   = axis_code(int'(center) - int'(upper));
         assign code = (mode == MODE_BOTH)
                     ? GRAD_W'(5'(gy) * 5'(AXIS_SPAN) + 5'(gx))
                     : GRAD_W'(gx);
      end else begin : g_horiz_only
         logic unused_ok;
         assign unused_ok = ^{center, upper, mode};
         assign code      = GRAD_W'(gx);
      end
   endgenerate
endmodule

// File: rtl/cgs_shade_lut.sv
module cgs_shade_lut #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8,
   localparam int ENTRIES = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (ADDR_W > 12) begin : g_bad_addr
         $error("cgs_shade_lut: ADDR_W too large");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [ENTRIES];

   // Read and write both use nonblocking updates, so a read sees the old entry.
   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem_q[rd_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_en;
   end

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R8
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R8
endmodule

// File: rtl/cgs_shader.sv
module cgs_shader
   import cgs_pkg::*;
#(
   parameter int COLOR_W = 4,
   parameter int DEPTH_W = 6,
   parameter int LINE_W  = 8,
   parameter int SHADE_W = 8,
   parameter bit VERT_EN = 1'b1,
   localparam int COL_W  = $clog2(LINE_W),
   localparam int WORD_W = COLOR_W + GRAD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bidir,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               in_sof,
   input  logic [COLOR_W-1:0] in_color,
   input  logic [DEPTH_W-1:0] in_depth,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_sof,
   output logic [WORD_W-1:0]  out_word,
   input  logic               lut_wr_en,
   input  logic [WORD_W-1:0]  lut_wr_addr,
   input  logic [SHADE_W-1:0] lut_wr_data,
   input  logic               lut_rd_en,
   input  logic [WORD_W-1:0]  lut_rd_addr,
   output logic               lut_rd_valid,
   output logic [SHADE_W-1:0] lut_rd_data
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_W - 1);

   generate
      if (LINE_W < 2) begin : g_bad_line
         $error("cgs_shader: LINE_W must be at least 2");
      end
      if (COLOR_W < 1 || DEPTH_W < 2) begin : g_bad_width
         $error("cgs_shader: COLOR_W or DEPTH_W too small");
      end
   endgenerate

   typedef struct packed {
      logic [COLOR_W-1:0] color;
      logic [DEPTH_W-1:0] depth;
      logic [DEPTH_W-1:0] left;
      logic [COL_W-1:0]   col;
      logic               top;
      logic               sof;
   } pix_t;

   // ---------------- input side: position tracking ----------------
   logic [COL_W-1:0]   col_q;
   logic               top_q;
   logic [DEPTH_W-1:0] prev_depth_q;
   logic               advance, accept;
   pix_t               in_pix;
   logic               in_last;

   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;
   assign accept   = in_valid && advance;

   always_comb begin
      in_pix.color = in_color;
      in_pix.depth = in_depth;
      in_pix.col   = in_sof ? '0 : col_q;
      in_pix.top   = in_sof ? 1'b1 : top_q;
      in_pix.sof   = in_sof;
      in_pix.left  = (in_pix.col == '0) ? in_depth : prev_depth_q;
   end
   assign in_last = (in_pix.col == LAST_COL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q        <= '0;
         top_q        <= 1'b1;
         prev_depth_q <= '0;
      end else if (accept) begin
         prev_depth_q <= in_depth;
         if (in_last) begin
            col_q <= '0;
            top_q <= 1'b0;
         end else begin
            col_q <= in_pix.col + 1'b1;
            top_q <= in_pix.top;
         end
      end
   end

   // ---------------- holding slots ----------------
   // pend: waits for its right neighbour; tail: last column, drains next cycle.
   pix_t pend_q, tail_q;
   logic pend_v, tail_v;
   logic emit_pend, emit_tail, emit;
   pix_t e_pix;
   logic [DEPTH_W-1:0] e_right, e_upper, lb_depth;
   logic [GRAD_W-1:0]  e_code;

   assign emit_pend = accept && pend_v;
   assign emit_tail = advance && tail_v;
   assign emit      = emit_pend || emit_tail;

   always_comb begin
      if (emit_tail) begin
         e_pix   = tail_q;
         e_right = tail_q.depth;
      end else begin
         e_pix   = pend_q;
         e_right = (in_pix.col == '0) ? pend_q.depth : in_depth;
      end
   end

   generate
      if (VERT_EN) begin : g_line
         cgs_line_buf #(.LINE_W(LINE_W), .DEPTH_W(DEPTH_W)) u_line (
            .clk      (clk),
            .rd_col   (e_pix.col),
            .rd_depth (lb_depth),
            .wr_en    (emit),
            .wr_col   (e_pix.col),
            .wr_depth (e_pix.depth)
         );
      end else begin : g_no_line
         assign lb_depth = '0;
      end
   endgenerate

   assign e_upper = e_pix.top ? e_pix.depth : lb_depth;

   cgs_grad_quant #(.DEPTH_W(DEPTH_W), .VERT_EN(VERT_EN)) u_quant (
      .center (e_pix.depth),
      .left   (e_pix.left),
      .right  (e_right),
      .upper  (e_upper),
      .mode   (grad_mode_e'(bidir)),
      .code   (e_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         tail_v    <= 1'b0;
         pend_q    <= '0;
         tail_q    <= '0;
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_word  <= '0;
      end else if (advance) begin
         out_valid <= emit;
         if (emit) begin
            out_word <= {e_pix.color, e_code};
            out_sof  <= e_pix.sof;
         end
         if (emit_tail) tail_v <= 1'b0;
         if (accept) begin
            if (in_last) begin
               tail_q <= in_pix;
               tail_v <= 1'b1;
               pend_v <= 1'b0;
            end else begin
               pend_q <= in_pix;
               pend_v <= 1'b1;
            end
         end
      end
   end

   // ---------------- shading table ----------------
   cgs_shade_lut #(.ADDR_W(WORD_W), .DATA_W(SHADE_W)) u_lut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lut_wr_en),
      .wr_addr  (lut_wr_addr),
      .wr_data  (lut_wr_data),
      .rd_en    (lut_rd_en),
      .rd_addr  (lut_rd_addr),
      .rd_valid (lut_rd_valid),
      .rd_data  (lut_rd_data)
   );

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word[GRAD_W-1:0] < (bidir ? 5'd25 : 5'd5))); // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_sof))); // R6
   AST_TAIL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_v && advance) |=> !tail_v); // R5
endmodule

// File: tb/cgs_shader_bench.sv
module cgs_shader_bench;
   localparam int CW = 4, DW = 6, LW = 8, SW = 8, WW = CW + 5;
   localparam int ROWS = 3, NPIX = LW * ROWS;

   // Frame table: {color, depth}, raster order, LW pixels per row.
   localparam logic [CW+DW-1:0] FRAME [NPIX] = '{
      {4'd1, 6'd10}, {4'd2, 6'd12}, {4'd3, 6'd12}, {4'd4, 6'd20},
      {4'd5, 6'd20}, {4'd6, 6'd18}, {4'd7, 6'd5},  {4'd8, 6'd5},
      {4'd9, 6'd11}, {4'd10,6'd12}, {4'd11,6'd30}, {4'd12,6'd20},
      {4'd13,6'd19}, {4'd14,6'd18}, {4'd15,6'd6},  {4'd0, 6'd0},
      {4'd3, 6'd11}, {4'd5, 6'd13}, {4'd7, 6'd29}, {4'd9, 6'd21},
      {4'd11,6'd19}, {4'd13,6'd17}, {4'd15,6'd63}, {4'd2, 6'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0, bidir = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
   logic [CW-1:0] in_color = '0;
   logic [DW-1:0] in_depth = '0;
   logic in_ready, out_valid, out_sof, lut_rd_valid;
   logic [WW-1:0] out_word;
   logic lut_wr_en = 1'b0, lut_rd_en = 1'b0;
   logic [WW-1:0] lut_wr_addr = '0, lut_rd_addr = '0;
   logic [SW-1:0] lut_wr_data = '0, lut_rd_data;

   always #4 clk = ~clk;

   cgs_shader #(.COLOR_W(CW), .DEPTH_W(DW), .LINE_W(LW), .SHADE_W(SW)) u_cgs_shader (
      .clk(clk), .rst_n(rst_n), .bidir(bidir),
      .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
      .in_color(in_color), .in_depth(in_depth),
      .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof), .out_word(out_word),
      .lut_wr_en(lut_wr_en), .lut_wr_addr(lut_wr_addr), .lut_wr_data(lut_wr_data),
      .lut_rd_en(lut_rd_en), .lut_rd_addr(lut_rd_addr),
      .lut_rd_valid(lut_rd_valid), .lut_rd_data(lut_rd_data)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int dep(input int i);
      return int'(FRAME[i][DW-1:0]);
   endfunction

   function automatic int clampc(input int d);
      return (d > 2) ? 2 : ((d < -2) ? -2 : d);
   endfunction

   function automatic logic [WW-1:0] exp_word(input int i, input bit bid);
      int r, c, d, lft, rgt, up, gx, gy, code;
      r = i / LW; c = i % LW; d = dep(i);
      lft = (c > 0) ? dep(i - 1) : d;
      rgt = (c < LW - 1) ? dep(i + 1) : d;
      up  = (r > 0) ? dep(i - LW) : d;
      gx = clampc(rgt - lft) + 2;
      gy = clampc(d - up) + 2;
      code = bid ? (gy * 5 + gx) : gx;
      return {FRAME[i][CW+DW-1:DW], 5'(code)};
   endfunction

   // Output collector and stall-stability monitor.
   logic [WW-1:0] got_word [128];
   bit got_sof [128];
   int ngot = 0, hold_viol = 0;
   bit hold_prev = 1'b0;
   logic [WW-1:0] word_prev = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_prev && !(out_valid && out_word == word_prev)) hold_viol++;
         hold_prev = out_valid && !out_ready;
         word_prev = out_word;
         if (out_valid && out_ready && ngot < 128) begin
            got_word[ngot] = out_word;
            got_sof[ngot]  = out_sof;
            ngot++;
         end
      end
   end

   // Periodic backpressure.
   bit bp_en = 1'b0;
   int bp_cnt = 0;
   always @(posedge clk) begin
      #1;
      if (bp_en) begin
         bp_cnt++;
         out_ready = (bp_cnt % 3) != 0;
      end
   end

   int in_stalls = 0;
   task automatic send_frame();
      for (int i = 0; i < NPIX; i++) begin
         bit ok;
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_color = FRAME[i][CW+DW-1:DW];
         in_depth = FRAME[i][DW-1:0];
         do begin
            @(negedge clk); ok = in_ready;
            if (!ok) in_stalls++;
            @(posedge clk); #1;
         end while (!ok);
      end
      in_valid = 1'b0;
      in_sof   = 1'b0;
   endtask

   task automatic lut_cycle(input bit we, input int wa, input int wd, input bit re, input int ra);
      lut_wr_en = we; lut_wr_addr = WW'(wa); lut_wr_data = SW'(wd);
      lut_rd_en = re; lut_rd_addr = WW'(ra);
      @(posedge clk); #1;
      lut_wr_en = 1'b0; lut_rd_en = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
      chk(lut_rd_valid == 1'b0, "R10 lut_rd_valid", lut_rd_valid, 0);
      chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
      @(posedge clk); #1;

      // Horizontal-only mode, free-running output.
      bidir = 1'b0; ngot = 0; in_stalls = 0;
      send_frame();
      repeat (6) @(posedge clk); #1;
      chk(ngot == NPIX, "R5 word count", ngot, NPIX);
      chk(in_stalls == 0, "R5 input stalls", in_stalls, 0);
      for (int i = 0; i < NPIX; i++) begin
         chk(got_word[i] == exp_word(i, 1'b0), "R1 R2 R4 word", got_word[i], exp_word(i, 1'b0));
         chk(got_sof[i] == (i == 0), "R7 sof", got_sof[i], (i == 0));
      end

      // Two-axis mode, two back-to-back frames under backpressure.
      bidir = 1'b1; ngot = 0; hold_viol = 0; bp_en = 1'b1;
      send_frame();
      send_frame();
      repeat (40) @(posedge clk);
      bp_en = 1'b0; #2 out_ready = 1'b1;
      repeat (4) @(posedge clk); #1;
      chk(ngot == 2 * NPIX, "R5 R6 word count", ngot, 2 * NPIX);
      chk(hold_viol == 0, "R6 hold violations", hold_viol, 0);
      for (int i = 0; i < 2 * NPIX; i++) begin
         chk(got_word[i] == exp_word(i % NPIX, 1'b1), "R3 R4 R7 word",
             got_word[i], exp_word(i % NPIX, 1'b1));
         chk(got_sof[i] == (i % NPIX == 0), "R7 sof", got_sof[i], (i % NPIX == 0));
      end

      // Shading table.
      lut_cycle(1'b1, 'h0A5, 'h3C, 1'b0, 0);
      lut_cycle(1'b0, 0, 0, 1'b1, 'h0A5);
      chk(lut_rd_valid == 1'b1, "R8 rd_valid", lut_rd_valid, 1);
      chk(lut_rd_data == 8'h3C, "R8 rd_data", lut_rd_data, 'h3C);
      @(negedge clk);
      chk(lut_rd_valid == 1'b0, "R8 rd_valid drop", lut_rd_valid, 0);
      lut_cycle(1'b1, 'h0A5, 'hC3, 1'b1, 'h0A5);
      chk(lut_rd_data == 8'h3C, "R9 old value", lut_rd_data, 'h3C);
      lut_cycle(1'b1, 'h0A4, 'h11, 1'b1, 'h0A5);
      chk(lut_rd_data == 8'hC3, "R9 new value", lut_rd_data, 'hC3);
      lut_cycle(1'b0, 0, 0, 1'b1, 'h0A4);
      chk(lut_rd_data == 8'h11, "R8 other address", lut_rd_data, 'h11);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule